// File: doc/BRIEF.md
# Byte-String Palindrome Checker Engine

This engine decides whether a run of bytes in memory reads the same forwards and backwards. The caller supplies two 16-bit byte addresses, a low pointer and a high pointer, and pulses a start input. The engine walks the two pointers toward each other. It reads one byte at each pointer through a single-byte request/ready memory port and compares the pair.

A matching pair moves the low pointer up by one and the high pointer down by one. The walk goes on while the low pointer stays below the high pointer. The first unequal pair ends the run at once. When the pointers meet or cross without a mismatch, the verdict is 1. The verdict register is cleared as soon as a run is accepted, so it stays 0 through the whole walk and after any mismatch. A completed run is marked by a one-cycle done pulse.

A launch whose high address is not strictly above its low address is undefined for the walk. The engine refuses it with a one-cycle error pulse and touches no memory.

Top module: `pal_engine`

## Requirements
- R1: After reset the engine is idle: busy, done, error and memory request are low and the verdict is 0.
- R2: A start pulse is taken only while the engine is idle. A start that arrives while busy is ignored and does not reload the pointers.
- R3: On an accepted start the verdict is cleared, so it reads 0 in the cycle after acceptance, whatever the previous run left.
- R4: If the high address is not greater than the low address at launch, the error output is high for exactly the one cycle after the start edge. No memory request is made, the verdict is 0 and no done pulse follows.
- R5: Each pair is read as two separate single-byte accesses, the low pointer first and then the high pointer. Each request holds its address stable until a cycle in which memory ready is high, and that cycle completes the access with the byte on the data input.
- R6: After a matching pair the low pointer increases by 1 and the high pointer decreases by 1. The next pair is read only if the new low pointer is still below the new high pointer.
- R7: On the first unequal pair the run ends with no further memory access. Done pulses in the next cycle with the verdict 0.
- R8: When the pointers meet or cross with every pair equal, done pulses with the verdict 1.
- R9: Done is high for exactly one cycle per walked run and is never high together with a memory request or the error output. The engine is idle in the cycle after done.
- R10: When the last pair before the pointers meet is unequal, the mismatch takes priority and the verdict is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse, taken only when idle |
| lo_addr_i | input | 16 | Starting low byte address |
| hi_addr_i | input | 16 | Starting high byte address |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 16 | Byte address of the current request |
| mem_ready_i | input | 1 | Memory ready; completes the pending read |
| mem_data_i | input | 8 | Byte returned in the ready cycle |
| busy_o | output | 1 | High whenever the engine is not idle |
| done_o | output | 1 | One-cycle pulse marking a final verdict |
| err_o | output | 1 | One-cycle pulse for a refused launch |
| result_o | output | 1 | Verdict: 1 palindrome, 0 otherwise |

## Verification
Two decisions can fall in the same cycle: the high-pointer read that exposes a mismatch can also be the read that would bring the pointers together. The bench provokes this with two-byte and odd/even strings whose innermost or only pair differs. It expects the mismatch to win, with the verdict 0. A second collision is a start pulse that arrives during a walk or in the done cycle. It is judged by checking that the requested addresses keep following the original run and that the verdict matches that run, against a cycle-level model fed with a randomly stalling ready line.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_LO = 3'd1,
    ST_RD_HI = 3'd2,
    ST_FIN   = 3'd3,
    ST_ERR   = 3'd4
  } pal_state_e;

  // A launch is defined only when the high address is strictly above the low one.
  function automatic logic span_defined(input logic [31:0] lo, input logic [31:0] hi);
    return hi > lo;
  endfunction

  // Evaluated on the pointers before a step: will the stepped pair still be ordered?
  function automatic logic walk_continues(input logic [31:0] lo, input logic [31:0] hi);
    return (lo + 32'd1) < (hi - 32'd1);
  endfunction

  function automatic logic [31:0] ptr_up(input logic [31:0] p);
    return p + 32'd1;
  endfunction

  function automatic logic [31:0] ptr_down(input logic [31:0] p);
    return p - 32'd1;
  endfunction

endpackage

// File: rtl/pal_ptr_unit.sv
module pal_ptr_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] lo_in_i,
  input  logic [AW-1:0] hi_in_i,
  output logic [AW-1:0] lo_o,
  output logic [AW-1:0] hi_o,
  output logic          span_ok_o,
  output logic          keep_going_o
);
  import pal_pkg::*;

  logic [AW-1:0] lo_q;
  logic [AW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load_i) begin
      lo_q <= lo_in_i;
      hi_q <= hi_in_i;
    end else if (step_i) begin
      lo_q <= AW'(ptr_up(32'(lo_q)));
      hi_q <= AW'(ptr_down(32'(hi_q)));
    end
  end

  assign span_ok_o    = span_defined(32'(lo_in_i), 32'(hi_in_i));
  assign keep_going_o = walk_continues(32'(lo_q), 32'(hi_q));
  assign lo_o         = lo_q;
  assign hi_o         = hi_q;

endmodule

// File: rtl/pal_cmp_unit.sv
module pal_cmp_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  output logic          eq_o
);

  logic [DW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (cap_i) begin
      held_q <= data_i;
    end
  end

  assign eq_o = (held_q == data_i);

endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic span_ok_i,
  input  logic mem_ready_i,
  input  logic bytes_eq_i,
  input  logic keep_going_i,
  output logic launch_o,
  output logic hs_lo_o,
  output logic hs_hi_o,
  output logic mismatch_o,
  output logic meet_o,
  output logic step_o,
  output logic sel_hi_o,
  output logic req_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic result_o
);
  import pal_pkg::*;

  pal_state_e state_q;
  pal_state_e state_d;
  logic       result_q;
  logic       accept;

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign launch_o   = accept && span_ok_i;
  assign hs_lo_o    = (state_q == ST_RD_LO) && mem_ready_i;
  assign hs_hi_o    = (state_q == ST_RD_HI) && mem_ready_i;
  assign mismatch_o = hs_hi_o && !bytes_eq_i;
  assign meet_o     = hs_hi_o && bytes_eq_i && !keep_going_i;
  assign step_o     = hs_hi_o && bytes_eq_i && keep_going_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = span_ok_i ? ST_RD_LO : ST_ERR;
      end
      ST_RD_LO: begin
        if (hs_lo_o) state_d = ST_RD_HI;
      end
      ST_RD_HI: begin
        if (mismatch_o || meet_o) state_d = ST_FIN;
        else if (step_o)          state_d = ST_RD_LO;
      end
      ST_FIN:  state_d = ST_IDLE;
      ST_ERR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      result_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept)      result_q <= 1'b0;
      else if (meet_o) result_q <= 1'b1;
    end
  end

  assign sel_hi_o = (state_q == ST_RD_HI);
  assign req_o    = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN);
  assign err_o    = (state_q == ST_ERR);
  assign result_o = result_q;

endmodule

// File: rtl/pal_engine.sv
module pal_engine #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] lo_addr_i,
  input  logic [AW-1:0] hi_addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          result_o
);

  logic          launch_ev;
  logic          hs_lo_ev;
  logic          hs_hi_ev;
  logic          mismatch_ev;
  logic          meet_ev;
  logic          step_ev;
  logic          sel_hi;
  logic          span_ok;
  logic          keep_going;
  logic          bytes_eq;
  logic [AW-1:0] lo_q;
  logic [AW-1:0] hi_q;

  pal_ptr_unit #(.AW(AW)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (launch_ev),
    .step_i       (step_ev),
    .lo_in_i      (lo_addr_i),
    .hi_in_i      (hi_addr_i),
    .lo_o         (lo_q),
    .hi_o         (hi_q),
    .span_ok_o    (span_ok),
    .keep_going_o (keep_going)
  );

  pal_cmp_unit #(.DW(DW)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (hs_lo_ev),
    .data_i (mem_data_i),
    .eq_o   (bytes_eq)
  );

  pal_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .span_ok_i    (span_ok),
    .mem_ready_i  (mem_ready_i),
    .bytes_eq_i   (bytes_eq),
    .keep_going_i (keep_going),
    .launch_o     (launch_ev),
    .hs_lo_o      (hs_lo_ev),
    .hs_hi_o      (hs_hi_ev),
    .mismatch_o   (mismatch_ev),
    .meet_o       (meet_ev),
    .step_o       (step_ev),
    .sel_hi_o     (sel_hi),
    .req_o        (mem_req_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .result_o     (result_o)
  );

  assign mem_addr_o = sel_hi ? hi_q : lo_q;

endmodule

// File: rtl/pal_engine_chk.sv
module pal_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          result_o,
  input logic          mem_req_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] lo_q,
  input logic [AW-1:0] hi_q,
  input logic          hs_lo_ev,
  input logic          mismatch_ev,
  input logic          meet_ev,
  input logic          step_ev
);

  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> !result_o); // R3

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o && !done_o); // R4

  AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !mem_req_o && !result_o); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> mem_req_o && $stable(mem_addr_o)); // R5

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lo_ev |=> mem_req_o && (mem_addr_o == hi_q)); // R5

  AST_POINTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> (lo_q == AW'($past(lo_q) + 1'b1)) && (hi_q == AW'($past(hi_q) - 1'b1))); // R6

  AST_MISMATCH_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_ev |=> done_o && !result_o && !mem_req_o); // R7

  AST_MEET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    meet_ev |=> done_o && result_o); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o); // R9

  AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o, mem_req_o})); // R9

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !step_ev) |=> $stable(lo_q) && $stable(hi_q)); // R2

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mismatch_ev, meet_ev, step_ev})); // R10

endmodule

bind pal_engine pal_engine_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .result_o    (result_o),
  .mem_req_o   (mem_req_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .lo_q        (lo_q),
  .hi_q        (hi_q),
  .hs_lo_ev    (hs_lo_ev),
  .mismatch_ev (mismatch_ev),
  .meet_ev     (meet_ev),
  .step_ev     (step_ev)
);

// File: tb/tb_pal_engine.sv
module tb_pal_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] lo_in = '0;
  logic [15:0] hi_in = '0;
  logic        ready = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        busy, done, err, result;

  logic [7:0]  mem_arr [0:255];
  logic [15:0] lfsr = 16'hACE1;
  bit          random_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign mem_data = mem_arr[mem_addr[7:0]];

  pal_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lo_addr_i(lo_in), .hi_addr_i(hi_in),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(ready), .mem_data_i(mem_data),
    .busy_o(busy), .done_o(done), .err_o(err), .result_o(result)
  );

  // ---------------- reference model: phase 0 idle, 1 low read, 2 high read, 3 done, 4 error
  int  m_phase = 0;
  int  m_lo = 0;
  int  m_hi = 0;
  int  m_byte = 0;
  bit  m_res = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_res = 1'b0; m_lo = 0; m_hi = 0;
    end else begin
      case (m_phase)
        0: if (start) begin
             m_res = 1'b0;
             if (int'(hi_in) > int'(lo_in)) begin
               m_lo = int'(lo_in); m_hi = int'(hi_in); m_phase = 1;
             end else m_phase = 4;
           end
        1: if (ready) begin m_byte = int'(mem_arr[m_lo % 256]); m_phase = 2; end
        2: if (ready) begin
             if (int'(mem_arr[m_hi % 256]) != m_byte) m_phase = 3;
             else begin
               m_lo = m_lo + 1; m_hi = m_hi - 1;
               if (m_lo < m_hi) m_phase = 1;
               else begin m_res = 1'b1; m_phase = 3; end
             end
           end
        default: m_phase = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == (m_phase != 0), "R2", "busy", int'(busy), int'(m_phase != 0));
      check(done == (m_phase == 3), "R9", "done", int'(done), int'(m_phase == 3));
      check(err == (m_phase == 4), "R4", "err", int'(err), int'(m_phase == 4));
      check(mem_req == (m_phase == 1 || m_phase == 2), "R5", "req", int'(mem_req),
            int'(m_phase == 1 || m_phase == 2));
      check(result == m_res, "R3", "result", int'(result), int'(m_res));
      if (m_phase == 1) check(int'(mem_addr) == m_lo, "R5", "low addr", int'(mem_addr), m_lo);
      if (m_phase == 2) check(int'(mem_addr) == m_hi, "R6", "high addr", int'(mem_addr), m_hi);
    end
  end

  // Ready line: always high or pseudo-random stalls
  always @(negedge clk) begin
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready <= random_ready ? lfsr[0] : 1'b1;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Independent ground truth for a span
  function automatic bit golden(input int lo, input int hi);
    int a = lo;
    int b = hi;
    while (a < b) begin
      if (mem_arr[a % 256] != mem_arr[b % 256]) return 1'b0;
      a++; b--;
    end
    return 1'b1;
  endfunction

  task automatic put(input int base, input string s);
    for (int i = 0; i < s.len(); i++) mem_arr[(base + i) % 256] = s[i];
  endtask

  task automatic run(input int lo, input int hi, input string req);
    bit exp;
    exp = golden(lo, hi);
    @(negedge clk);
    start = 1'b1; lo_in = 16'(lo); hi_in = 16'(hi);
    @(negedge clk);
    start = 1'b0;
    check(result == 1'b0, "R3", "verdict cleared on accept", int'(result), 0);
    while (!done && !err) @(negedge clk);
    check(done && !err, req, "run ends with done", int'(done), 1);
    check(result == exp, req, "verdict", int'(result), int'(exp));
    @(negedge clk);
    check(!busy && !done, "R9", "idle after done", int'(busy), 0);
  endtask

  task automatic run_bad(input int lo, input int hi);
    @(negedge clk);
    start = 1'b1; lo_in = 16'(lo); hi_in = 16'(hi);
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1, "R4", "error pulse", int'(err), 1);
    check(mem_req == 1'b0 && done == 1'b0, "R4", "no read or done", int'(mem_req), 0);
    check(result == 1'b0, "R4", "verdict zero", int'(result), 0);
    @(negedge clk);
    check(err == 1'b0 && !busy, "R4", "error one cycle", int'(err), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_arr[i] = 8'(i * 7 + 3);
    put(10, "racecar");
    put(30, "abba");
    put(40, "abcd");
    put(50, "abcxba");
    put(60, "ab");
    put(70, "qq");
    put(80, "abcdXcba");
    put(100, "level");
    put(240, "0123443210");

    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !mem_req && !result, "R1", "reset state",
          int'({busy, done, err, mem_req, result}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req, "R1", "idle after reset", int'({busy, mem_req}), 0);

    for (int pass = 0; pass < 2; pass++) begin
      random_ready = (pass == 1);
      run(10, 16, "R8");      // odd palindrome
      run(30, 33, "R8");      // even palindrome
      run(40, 43, "R7");      // first pair differs
      run(50, 55, "R7");      // middle pair differs
      run(60, 61, "R10");     // only pair differs
      run(70, 71, "R8");      // two equal bytes
      run(80, 87, "R10");     // innermost pair differs
      run(100, 104, "R8");
      run(16'hFFF0, 16'hFFF9, "R8"); // addresses near the top of the space
      run_bad(20, 20);
      run_bad(25, 5);
    end

    // Start pulses while busy and in the done cycle are ignored (R2)
    random_ready = 1'b1;
    @(negedge clk);
    start = 1'b1; lo_in = 16'd10; hi_in = 16'd16;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; lo_in = 16'd40; hi_in = 16'd43;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(result == 1'b1, "R2", "busy start ignored verdict", int'(result), 1);
    start = 1'b1; lo_in = 16'd25; hi_in = 16'd5;
    @(negedge clk);
    start = 1'b0;
    check(!err && !busy, "R2", "start in done cycle ignored", int'({err, busy}), 0);
    @(negedge clk);
    run(30, 33, "R3");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule